// File: doc/BRIEF.md
# Byte/Word Flash Bus Front-End with Boot-Block Decode

This block sits between an asynchronous parallel memory bus and the core of a 1 Mbit flash with an asymmetric block layout. The bus has active-low chip select, read strobe and write strobe, a mode pin that picks 8-bit or 16-bit access, a 16-bit word address and a 16-bit data bus. In 8-bit mode the top data line is an input that carries the least significant byte-address bit. The block forms a 17-bit byte address for reads and writes. It steers the array word onto the correct byte lanes and produces per-lane output-drive enables for the pad ring.

Write strobes are brought into the system clock domain through two-stage synchronisers. A write cycle runs while both chip select and write strobe are low. The address is captured when that combined window opens, which is the later of the two falling edges. The data is captured when the window closes, which is the earlier of the two rising edges. The captured cycle is then handed to the command logic as a one-cycle pulse.

A build parameter picks a top-boot or a bottom-boot block map. Both the live bus address and the captured write address are decoded into a 3-bit block index.

Top module: `flash_bus_frontend`

## Requirements
- R1: The output lanes are enabled only while `ce_ni`=0, `oe_ni`=0 and `hw_rst_ni`=1. Otherwise `dq_oe_o` is 3'b000. `dq_oe_o` bit 0 covers lines 7:0, bit 1 covers lines 14:8 and bit 2 covers line 15.
- R2: In word mode (`word_mode_i`=1), `dq_o` equals `rd_data_i`, all three lane enables follow R1, and `rd_addr_o` = {`addr_i`, 1'b0}.
- R3: In byte mode (`word_mode_i`=0), `dq_o[7:0]` is `rd_data_i[15:8]` when `dq_i[15]`=1 and `rd_data_i[7:0]` when `dq_i[15]`=0. `rd_addr_o` = {`addr_i`, `dq_i[15]`}, and lane enables 1 and 2 stay 0.
- R4: A write captures the address in the cycle where the combined window (`ce_ni`=0 and `we_ni`=0) opens, which is the later falling strobe. Address changes made later inside the window are ignored.
- R5: A write captures the data where the window closes, which is the first rising strobe. `wr_valid_o` is then high for exactly one cycle.
- R6: The captured byte address `wr_addr_o` is {`addr_i`, 1'b0} for a word-mode write and {`addr_i`, `dq_i[15]`} for a byte-mode write. Both are sampled when the window opens.
- R7: `wr_cmd_o` is always data bits 7:0, so the upper byte has no effect on it. In byte mode `wr_data_o[15:8]` is 0. In word mode `wr_data_o` is the full 16-bit bus.
- R8: With `BOOT_TOP`=1, the block index in ascending byte-address order is 0 for 00000h-0FFFFh, 1 for 10000h-17FFFh, 2 for 18000h-19FFFh, 3 for 1A000h-1BFFFh and 4 for 1C000h-1FFFFh.
- R9: With `BOOT_TOP`=0, the block index is 0 for 00000h-03FFFh, 1 for 04000h-05FFFh, 2 for 06000h-07FFFh, 3 for 08000h-0FFFFh and 4 for 10000h-1FFFFh.
- R10: While `hw_rst_ni`=0, no write completes. A window that is open when reset falls produces no `wr_valid_o`.
- R11: `rd_blk_o` decodes `rd_addr_o`, and `rd_blk_vld_o` equals the inverse of `ce_ni`. `wr_blk_o` decodes `wr_addr_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| ce_ni | input | 1 | Chip select, active low |
| oe_ni | input | 1 | Read strobe, active low |
| we_ni | input | 1 | Write strobe, active low |
| hw_rst_ni | input | 1 | Bus-side reset pin, active low |
| word_mode_i | input | 1 | 1 selects 16-bit access, 0 selects 8-bit access |
| addr_i | input | 16 | Word address |
| dq_i | input | 16 | Data bus input; bit 15 is the byte select in byte mode |
| rd_data_i | input | 16 | Array word at the current address |
| dq_o | output | 16 | Data bus output value |
| dq_oe_o | output | 3 | Drive enables for the three lane groups |
| rd_addr_o | output | 17 | Live byte address |
| rd_blk_o | output | 3 | Block index of the live address |
| rd_blk_vld_o | output | 1 | Live block index is valid |
| wr_valid_o | output | 1 | One-cycle pulse for a completed write |
| wr_addr_o | output | 17 | Captured byte address |
| wr_data_o | output | 16 | Captured write data |
| wr_cmd_o | output | 8 | Captured command byte |
| wr_word_o | output | 1 | Captured cycle was word mode |
| wr_blk_o | output | 3 | Block index of the captured address |

## Verification
The hardest case to produce is a write where the two strobes overlap only partly. The address must come from the moment the second strobe falls, and the data from the moment the first one rises. The bench drops the write strobe first and moves the address while chip select is still high. Then it drops chip select and moves the address again inside the window. At the end it raises the write strobe while still holding chip select low, and changes the data only after the capture pulse. A further case pulls the bus reset low in the middle of an open window.

// File: rtl/flash_fe_pkg.sv
package flash_fe_pkg;
  localparam int unsigned BLK_W = 3;

  // index in ascending address order; a = word address bits 15:12
  function automatic logic [BLK_W-1:0] blk_index(input logic [3:0] a, input bit top);
    logic [BLK_W-1:0] r;
    if (top) begin
      casez (a)
        4'b0???: r = 3'd0;
        4'b10??: r = 3'd1;
        4'b1100: r = 3'd2;
        4'b1101: r = 3'd3;
        default: r = 3'd4;
      endcase
    end else begin
      casez (a)
        4'b000?: r = 3'd0;
        4'b0010: r = 3'd1;
        4'b0011: r = 3'd2;
        4'b01??: r = 3'd3;
        default: r = 3'd4;
      endcase
    end
    return r;
  endfunction
endpackage

// File: rtl/flash_blk_decode.sv
module flash_blk_decode
  import flash_fe_pkg::*;
#(
  parameter bit BOOT_TOP = 1'b1
) (
  input  logic [3:0]       hi_i,
  output logic [BLK_W-1:0] blk_o
);
  generate
    if (BOOT_TOP) begin : g_top
      assign blk_o = blk_index(hi_i, 1'b1);
    end else begin : g_bot
      assign blk_o = blk_index(hi_i, 1'b0);
    end
  endgenerate
endmodule

// File: rtl/flash_strobe_sync.sv
module flash_strobe_sync #(
  parameter int unsigned N      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] d_i,
  output logic [N-1:0] q_o
);
  logic [N-1:0] stg_q [STAGES];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '1;  // strobes idle high
    end else begin
      stg_q[0] <= d_i;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/flash_wr_capture.sv
module flash_wr_capture #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned BA_W  = ADDR_W + 1,
  localparam int unsigned HALF  = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_s_ni,
  input  logic              we_s_ni,
  input  logic              hw_rst_ni,
  input  logic              word_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  output logic              wr_valid_o,
  output logic [BA_W-1:0]   wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [HALF-1:0]   wr_cmd_o,
  output logic              wr_word_o
);
  logic win, win_q, armed_q, open_ev, close_ev;
  logic [BA_W-1:0] live_ba;

  assign win      = ~ce_s_ni & ~we_s_ni & hw_rst_ni;
  assign open_ev  = win & ~win_q;
  assign close_ev = ~win & win_q & armed_q & hw_rst_ni;
  assign live_ba  = {addr_i, word_mode_i ? 1'b0 : dq_i[DATA_W-1]};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q      <= 1'b0;
      armed_q    <= 1'b0;
      wr_valid_o <= 1'b0;
      wr_addr_o  <= '0;
      wr_data_o  <= '0;
      wr_cmd_o   <= '0;
      wr_word_o  <= 1'b0;
    end else begin
      win_q      <= win;
      wr_valid_o <= close_ev;
      if (open_ev) begin
        wr_addr_o <= live_ba;
        wr_word_o <= word_mode_i;
        armed_q   <= 1'b1;
      end
      if (close_ev) begin
        wr_data_o <= wr_word_o ? dq_i : {{HALF{1'b0}}, dq_i[HALF-1:0]};
        wr_cmd_o  <= dq_i[HALF-1:0];
        armed_q   <= 1'b0;
      end
      if (!hw_rst_ni) armed_q <= 1'b0;
    end
  end
endmodule

// File: rtl/flash_rd_lanes.sv
module flash_rd_lanes #(
  parameter int unsigned DATA_W = 16,
  localparam int unsigned HALF  = DATA_W / 2
) (
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              hw_rst_ni,
  input  logic              word_mode_i,
  input  logic              byte_sel_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] dq_o,
  output logic [2:0]        dq_oe_o
);
  logic drive;
  assign drive = ~ce_ni & ~oe_ni & hw_rst_ni;

  always_comb begin
    if (word_mode_i) begin
      dq_o = rd_data_i;
    end else begin
      dq_o = '0;
      dq_o[HALF-1:0] = byte_sel_i ? rd_data_i[DATA_W-1:HALF] : rd_data_i[HALF-1:0];
    end
    dq_oe_o = {drive & word_mode_i, drive & word_mode_i, drive};
  end
endmodule

// File: rtl/flash_bus_frontend.sv
module flash_bus_frontend
  import flash_fe_pkg::*;
#(
  parameter bit          BOOT_TOP = 1'b1,
  parameter int unsigned ADDR_W   = 16,
  parameter int unsigned DATA_W   = 16,
  localparam int unsigned BA_W    = ADDR_W + 1,
  localparam int unsigned HALF    = DATA_W / 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ce_ni,
  input  logic              oe_ni,
  input  logic              we_ni,
  input  logic              hw_rst_ni,
  input  logic              word_mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] dq_i,
  input  logic [DATA_W-1:0] rd_data_i,
  output logic [DATA_W-1:0] dq_o,
  output logic [2:0]        dq_oe_o,
  output logic [BA_W-1:0]   rd_addr_o,
  output logic [BLK_W-1:0]  rd_blk_o,
  output logic              rd_blk_vld_o,
  output logic              wr_valid_o,
  output logic [BA_W-1:0]   wr_addr_o,
  output logic [DATA_W-1:0] wr_data_o,
  output logic [HALF-1:0]   wr_cmd_o,
  output logic              wr_word_o,
  output logic [BLK_W-1:0]  wr_blk_o
);
  logic [1:0] strb_s;

  assign rd_addr_o    = {addr_i, word_mode_i ? 1'b0 : dq_i[DATA_W-1]};
  assign rd_blk_vld_o = ~ce_ni;

  flash_strobe_sync #(.N(2), .STAGES(2)) u_sync (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .d_i   ({ce_ni, we_ni}),
    .q_o   (strb_s)
  );

  flash_wr_capture #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_wr (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .ce_s_ni    (strb_s[1]),
    .we_s_ni    (strb_s[0]),
    .hw_rst_ni  (hw_rst_ni),
    .word_mode_i(word_mode_i),
    .addr_i     (addr_i),
    .dq_i       (dq_i),
    .wr_valid_o (wr_valid_o),
    .wr_addr_o  (wr_addr_o),
    .wr_data_o  (wr_data_o),
    .wr_cmd_o   (wr_cmd_o),
    .wr_word_o  (wr_word_o)
  );

  flash_rd_lanes #(.DATA_W(DATA_W)) u_rd (
    .ce_ni      (ce_ni),
    .oe_ni      (oe_ni),
    .hw_rst_ni  (hw_rst_ni),
    .word_mode_i(word_mode_i),
    .byte_sel_i (dq_i[DATA_W-1]),
    .rd_data_i  (rd_data_i),
    .dq_o       (dq_o),
    .dq_oe_o    (dq_oe_o)
  );

  flash_blk_decode #(.BOOT_TOP(BOOT_TOP)) u_rd_dec (
    .hi_i (rd_addr_o[BA_W-1 -: 4]),
    .blk_o(rd_blk_o)
  );

  flash_blk_decode #(.BOOT_TOP(BOOT_TOP)) u_wr_dec (
    .hi_i (wr_addr_o[BA_W-1 -: 4]),
    .blk_o(wr_blk_o)
  );
endmodule

// File: rtl/flash_bus_frontend_chk.sv
module flash_bus_frontend_chk (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        ce_ni,
  input logic        oe_ni,
  input logic        hw_rst_ni,
  input logic        word_mode_i,
  input logic [2:0]  dq_oe_o,
  input logic [2:0]  rd_blk_o,
  input logic        wr_valid_o,
  input logic [16:0] wr_addr_o,
  input logic [15:0] wr_data_o,
  input logic [7:0]  wr_cmd_o,
  input logic        wr_word_o,
  input logic [2:0]  wr_blk_o
);
  a_r1_float_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce_ni || oe_ni || !hw_rst_ni) |-> dq_oe_o == 3'b000);

  a_r3_byte_upper_float: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !word_mode_i |-> dq_oe_o[2:1] == 2'b00);

  a_r5_single_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |=> !wr_valid_o);

  a_r6_word_lsb_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_o && wr_word_o) |-> wr_addr_o[0] == 1'b0);

  a_r7_cmd_low_byte: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_valid_o |-> (wr_cmd_o == wr_data_o[7:0] &&
                    (wr_word_o || wr_data_o[15:8] == 8'h00)));

  a_r10_no_write_in_reset: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hw_rst_ni |=> !wr_valid_o);

  a_r11_blk_in_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_blk_o <= 3'd4) && (wr_blk_o <= 3'd4));
endmodule

bind flash_bus_frontend flash_bus_frontend_chk u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .ce_ni      (ce_ni),
  .oe_ni      (oe_ni),
  .hw_rst_ni  (hw_rst_ni),
  .word_mode_i(word_mode_i),
  .dq_oe_o    (dq_oe_o),
  .rd_blk_o   (rd_blk_o),
  .wr_valid_o (wr_valid_o),
  .wr_addr_o  (wr_addr_o),
  .wr_data_o  (wr_data_o),
  .wr_cmd_o   (wr_cmd_o),
  .wr_word_o  (wr_word_o),
  .wr_blk_o   (wr_blk_o)
);

// File: tb/flash_bus_frontend_test.sv
module flash_bus_frontend_test;
  logic clk = 1'b0, rst_n = 1'b0;
  logic ce_n = 1, oe_n = 1, we_n = 1, hw_rst_n = 1, word_mode = 1;
  logic [15:0] addr = '0, dq_in = '0, rd_data = '0;
  logic [15:0] dq_o, dq_o_b, wr_data, wr_data_b;
  logic [2:0]  dq_oe, dq_oe_b, rd_blk, rd_blk_b, wr_blk, wr_blk_b;
  logic [16:0] rd_addr, rd_addr_b, wr_addr, wr_addr_b;
  logic        rd_vld, rd_vld_b, wr_valid, wr_valid_b, wr_word, wr_word_b;
  logic [7:0]  wr_cmd, wr_cmd_b;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  flash_bus_frontend #(.BOOT_TOP(1'b1)) uut (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .hw_rst_ni(hw_rst_n), .word_mode_i(word_mode), .addr_i(addr), .dq_i(dq_in),
    .rd_data_i(rd_data), .dq_o(dq_o), .dq_oe_o(dq_oe), .rd_addr_o(rd_addr),
    .rd_blk_o(rd_blk), .rd_blk_vld_o(rd_vld), .wr_valid_o(wr_valid),
    .wr_addr_o(wr_addr), .wr_data_o(wr_data), .wr_cmd_o(wr_cmd),
    .wr_word_o(wr_word), .wr_blk_o(wr_blk));

  flash_bus_frontend #(.BOOT_TOP(1'b0)) uut_b (
    .clk_i(clk), .rst_ni(rst_n), .ce_ni(ce_n), .oe_ni(oe_n), .we_ni(we_n),
    .hw_rst_ni(hw_rst_n), .word_mode_i(word_mode), .addr_i(addr), .dq_i(dq_in),
    .rd_data_i(rd_data), .dq_o(dq_o_b), .dq_oe_o(dq_oe_b), .rd_addr_o(rd_addr_b),
    .rd_blk_o(rd_blk_b), .rd_blk_vld_o(rd_vld_b), .wr_valid_o(wr_valid_b),
    .wr_addr_o(wr_addr_b), .wr_data_o(wr_data_b), .wr_cmd_o(wr_cmd_b),
    .wr_word_o(wr_word_b), .wr_blk_o(wr_blk_b));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int exp_blk(input int ba, input bit top);
    if (top) return ba < 'h10000 ? 0 : ba < 'h18000 ? 1 : ba < 'h1A000 ? 2 : ba < 'h1C000 ? 3 : 4;
    return ba < 'h4000 ? 0 : ba < 'h6000 ? 1 : ba < 'h8000 ? 2 : ba < 'h10000 ? 3 : 4;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  // wait for the capture pulse; returns 1 if seen
  task automatic wait_wr(output bit seen);
    seen = 0;
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      if (wr_valid) begin
        seen = 1;
        @(negedge clk);
        chk(!wr_valid, "R5 pulse width", wr_valid, 0);
        return;
      end
    end
  endtask

  task automatic t_reset;
    chk(dq_oe == 3'b000, "R1 reset lanes", dq_oe, 0);
    chk(!wr_valid && wr_addr == 0, "R5 reset write", wr_addr, 0);
  endtask

  task automatic t_read_word;
    word_mode = 1; addr = 16'hC123; rd_data = 16'hA55A; ce_n = 0; oe_n = 0; cyc(1);
    chk(dq_oe == 3'b111, "R1 word lanes", dq_oe, 7);
    chk(dq_o == 16'hA55A, "R2 word data", dq_o, 16'hA55A);
    chk(rd_addr == 17'h18246, "R2 word addr", rd_addr, 17'h18246);
    oe_n = 1; cyc(1);
    chk(dq_oe == 0, "R1 oe high", dq_oe, 0);
    oe_n = 0; hw_rst_n = 0; cyc(1);
    chk(dq_oe == 0, "R1 bus reset low", dq_oe, 0);
    hw_rst_n = 1; ce_n = 1; cyc(1);
    chk(dq_oe == 0 && !rd_vld, "R1 R11 deselected", dq_oe, 0);
    oe_n = 1;
  endtask

  task automatic t_read_byte;
    word_mode = 0; addr = 16'h0010; rd_data = 16'h3C96; ce_n = 0; oe_n = 0;
    dq_in = 16'h8000; cyc(1);
    chk(dq_o[7:0] == 8'h3C, "R3 upper byte", dq_o[7:0], 8'h3C);
    chk(dq_oe == 3'b001, "R3 lanes", dq_oe, 1);
    chk(rd_addr == 17'h00021, "R3 addr odd", rd_addr, 17'h21);
    dq_in = 16'h0000; cyc(1);
    chk(dq_o[7:0] == 8'h96, "R3 lower byte", dq_o[7:0], 8'h96);
    chk(rd_addr == 17'h00020, "R3 addr even", rd_addr, 17'h20);
    ce_n = 1; oe_n = 1; word_mode = 1;
  endtask

  task automatic t_decode;
    logic [15:0] wl [14] = '{16'h0000, 16'h7FFF, 16'h8000, 16'hBFFF, 16'hC000, 16'hCFFF,
                             16'hD000, 16'hDFFF, 16'hE000, 16'hFFFF, 16'h1FFF, 16'h2000,
                             16'h3000, 16'h4000};
    ce_n = 0;
    for (int m = 0; m < 2; m++) begin
      word_mode = m[0];
      for (int i = 0; i < 14; i++) begin
        int ba;
        addr = wl[i]; dq_in = {wl[i][0], 15'h0};
        ba = word_mode ? {wl[i], 1'b0} : {wl[i], wl[i][0]};
        cyc(1);
        chk(rd_vld && rd_blk == 3'(exp_blk(ba, 1)), "R8 top map", rd_blk, exp_blk(ba, 1));
        chk(rd_blk_b == 3'(exp_blk(ba, 0)), "R9 bottom map", rd_blk_b, exp_blk(ba, 0));
      end
    end
    ce_n = 1; word_mode = 1; dq_in = '0;
  endtask

  task automatic t_write_word_overlap;
    bit seen;
    word_mode = 1; addr = 16'h1111; dq_in = 16'hBEEF;
    we_n = 0; cyc(4);
    addr = 16'hD004;              // later falling strobe decides
    cyc(1); ce_n = 0; cyc(5);
    addr = 16'h0100;              // R4 change inside window ignored
    dq_in = 16'hABCD; cyc(2);
    we_n = 1;                     // first rising strobe
    wait_wr(seen);
    chk(seen, "R5 word write pulse", seen, 1);
    chk(wr_addr == 17'h1A008, "R4 R6 word addr", wr_addr, 17'h1A008);
    chk(wr_data == 16'hABCD && wr_word, "R7 word data", wr_data, 16'hABCD);
    chk(wr_cmd == 8'hCD, "R7 cmd low byte", wr_cmd, 8'hCD);
    chk(wr_blk == 3'd3 && wr_blk_b == 3'd4, "R11 write block", wr_blk, 3);
    dq_in = 16'h0000; cyc(3); ce_n = 1; cyc(6);
    chk(!wr_valid, "R5 no second pulse", wr_valid, 0);
  endtask

  task automatic t_write_byte;
    bit seen;
    word_mode = 0; addr = 16'h0005; dq_in = 16'h8000 | 16'h7F5A;
    ce_n = 0; cyc(2); we_n = 0; cyc(4);
    dq_in = 16'h0000 | 16'h2277;  // byte select drops after open: ignored for address
    cyc(2); ce_n = 1;
    wait_wr(seen);
    chk(seen, "R5 byte write pulse", seen, 1);
    chk(wr_addr == 17'h0000B, "R6 byte addr", wr_addr, 17'hB);
    chk(wr_data == 16'h0077 && !wr_word, "R7 byte data", wr_data, 16'h77);
    chk(wr_cmd == 8'h77, "R7 cmd byte", wr_cmd, 8'h77);
    chk(wr_blk == 0 && wr_blk_b == 0, "R8 R9 write block", wr_blk_b, 0);
    we_n = 1; word_mode = 1; cyc(6);
  endtask

  task automatic t_write_in_reset;
    bit seen;
    addr = 16'h2222; dq_in = 16'h1234; ce_n = 0; we_n = 0; cyc(6);
    hw_rst_n = 0; cyc(3); we_n = 1; ce_n = 1; cyc(4); hw_rst_n = 1;
    wait_wr(seen);
    chk(!seen, "R10 write dropped", seen, 0);
    chk(wr_addr != 17'h04444 || wr_data != 16'h1234, "R10 no capture", wr_data, 0);
  endtask

  initial begin : watchdog
    #400000;
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    cyc(3); rst_n = 1; cyc(3);
    t_reset();
    t_read_word();
    t_read_byte();
    t_decode();
    t_write_word_overlap();
    t_write_byte();
    t_write_in_reset();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule